// File: doc/BRIEF.md
# Routed Pin Interrupt Controller

This block watches up to 32 pin inputs and drives a single interrupt line. Pins come from four 16-bit ports. Each byte lane of the 32-bit sense vector is fed by an 8-bit half of one port. A routing register chooses which port feeds each lane. Even lanes always take the lower half of a port, and odd lanes always take the upper half. To place a whole 16-bit port on one half of the sense vector, software writes the same port code into both bytes of that half.

Every sense bit has an optional inversion stage in front of a detector that sees only rising edges or high levels. This lets falling-edge and active-low sources be handled. An edge-mode bit latches its request until software clears it. A level-mode bit follows its qualified input. Masks, edge selects and inversions are each reached through a write-one-set address and a write-one-clear address. Software uses a small synchronous register bus with a single-cycle write strobe and a combinational read port.

Top module: `pin_irq_router`

## Requirements
- R1: After reset the routing, mask, edge, invert and request registers all read zero, and `irq_out` is low.
- R2: Sense byte lane k (bits 8k+7..8k) is driven from the port whose index is bits 1..0 of routing byte k. Even lanes take bits 7..0 of that port, and odd lanes take bits 15..8. Bits 7..2 of each routing byte have no effect on routing.
- R3: Port inputs pass through two flip-flops. A pin change made before clock edge 0 shows up in the request register after edge 2, and not after edge 1.
- R4: When a bit has edge mode set, its request is latched when the qualified input goes from 0 to 1. The request stays set after the input returns to 0.
- R5: Writing to address 3 clears every edge-mode request bit that is written as 1. Bits written as 0 are left unchanged.
- R6: If a new rising edge arrives in the same cycle as a clear write for that bit, the request is left set.
- R7: When a bit has edge mode clear (level mode), its request follows the qualified input on every cycle. A clear write has no lasting effect on that bit.
- R8: The invert bit flips a sense input before detection. With invert set, a falling pin edge latches in edge mode, and a low pin raises the request in level mode.
- R9: The mask, edge and invert registers are each written with 1 to set at addresses 1, 4 and 6, and with 1 to clear at addresses 2, 5 and 7. Bits written as 0 are not changed. Either address of a pair reads back the current value. Address 0 is the routing register, which is read/write.
- R10: Writing all ones to the mask-clear address drops `irq_out` on the next cycle.
- R11: `irq_out` is high exactly when some request bit is set and its mask bit is set.
- R12: Address 8 reads the qualified sense vector, which is the value after synchronising, routing and inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_in | input | 64 | Four 16-bit pin ports; port p is bits 16p+15..16p |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt request |

## Verification
A wrong routing select or a wrong invert bit shows at the sense read address two clock edges after the pin changes. It also shows as a request that is missing or spurious one edge later. A corrupted request latch or corrupted previous-level register shows at once at the request address and, if the bit is masked in, on `irq_out` in the same cycle. The clear-versus-edge collision is driven at the exact cycle in which the edge is registered, so a design that gives priority to the clear loses the request where it can be seen.

// File: rtl/pir_pkg.sv
// Shared constants for the routed pin interrupt controller.
// Assumes a word-addressed register bus with 4 address bits.
package pir_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] ADDR_ROUTE    = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK_SET = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_MASK_CLR = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_REQ      = 4'd3;
    localparam logic [ADDR_W-1:0] ADDR_EDGE_SET = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_EDGE_CLR = 4'd5;
    localparam logic [ADDR_W-1:0] ADDR_INV_SET  = 4'd6;
    localparam logic [ADDR_W-1:0] ADDR_INV_CLR  = 4'd7;
    localparam logic [ADDR_W-1:0] ADDR_SENSE    = 4'd8;
endpackage

// File: rtl/pir_sync.sv
// Two-stage synchronizer for a vector of asynchronous pin inputs.
// Assumes that bits are independent; no bus coherency is provided.
module pir_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    // Shift the raw inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/pir_route.sv
// Steers port halves into sense byte lanes, then applies per-bit inversion.
// Even lanes take the low half of the selected port and odd lanes take the high half.
module pir_route #(
    parameter int PORTS  = 4,
    parameter int PORT_W = 16,
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int SEL_W = $clog2(PORTS),
    localparam int SENSE_W = LANES * LANE_W
) (
    input  logic [PORTS*PORT_W-1:0] ports,
    input  logic [LANES*SEL_W-1:0]  sel,
    input  logic [SENSE_W-1:0]      inv,
    output logic [SENSE_W-1:0]      qual
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HALF_OFF = (k % 2) * LANE_W;
        logic [LANE_W-1:0] lane_src;

        // Pick the selected port's half for this lane.
        always_comb begin
            lane_src = '0;
            for (int p = 0; p < PORTS; p++) begin
                if (sel[k*SEL_W +: SEL_W] == SEL_W'(p))
                    lane_src = ports[p*PORT_W + HALF_OFF +: LANE_W];
            end
        end

        assign qual[k*LANE_W +: LANE_W] = lane_src ^ inv[k*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/pir_regs.sv
// Configuration registers: routing (read/write), and mask, edge and invert
// (each a write-one-set / write-one-clear pair). Also produces the request-clear pulse.
module pir_regs #(
    parameter int W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [pir_pkg::ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]              bus_wdata,
    output logic [W-1:0]              route_q,
    output logic [W-1:0]              mask_q,
    output logic [W-1:0]              edge_q,
    output logic [W-1:0]              inv_q,
    output logic [W-1:0]              req_clr
);
    import pir_pkg::*;

    function automatic logic [W-1:0] upd(input logic [W-1:0] cur, input logic s,
                                         input logic c, input logic [W-1:0] d);
        return (cur | (s ? d : '0)) & ~(c ? d : '0);
    endfunction

    // Apply bus writes to the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
            mask_q  <= '0;
            edge_q  <= '0;
            inv_q   <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_ROUTE) route_q <= bus_wdata;
            mask_q <= upd(mask_q, bus_addr == ADDR_MASK_SET, bus_addr == ADDR_MASK_CLR, bus_wdata);
            edge_q <= upd(edge_q, bus_addr == ADDR_EDGE_SET, bus_addr == ADDR_EDGE_CLR, bus_wdata);
            inv_q  <= upd(inv_q,  bus_addr == ADDR_INV_SET,  bus_addr == ADDR_INV_CLR,  bus_wdata);
        end
    end

    assign req_clr = (bus_we && bus_addr == ADDR_REQ) ? bus_wdata : '0;
endmodule

// File: rtl/pir_detect.sv
// Per-bit request logic: edge bits latch on a 0->1 qualified transition until
// cleared (an edge wins over a clear); level bits track the qualified input.
module pir_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] qual,
    input  logic [W-1:0] edge_mode,
    input  logic [W-1:0] clr,
    output logic [W-1:0] req,
    output logic [W-1:0] qual_d
);
    logic [W-1:0] rise;
    assign rise = qual & ~qual_d;

    // Keep the previous qualified level and update the requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_d <= '0;
            req    <= '0;
        end else begin
            qual_d <= qual;
            req    <= (edge_mode & ((req & ~clr) | rise)) | (~edge_mode & qual);
        end
    end
endmodule

// File: rtl/pin_irq_router.sv
// Top of the routed pin interrupt controller. Synchronizes the ports, routes
// them into the sense vector, detects requests and drives a masked interrupt.
module pin_irq_router #(
    parameter int PORTS  = 4,
    parameter int PORT_W = 16,
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int SEL_W   = $clog2(PORTS),
    localparam int SENSE_W = LANES * LANE_W,
    localparam int IN_W    = PORTS * PORT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IN_W-1:0]            port_in,
    input  logic                       bus_we,
    input  logic [pir_pkg::ADDR_W-1:0] bus_addr,
    input  logic [SENSE_W-1:0]         bus_wdata,
    output logic [SENSE_W-1:0]         bus_rdata,
    output logic                       irq_out
);
    import pir_pkg::*;

    logic [IN_W-1:0]        ports_s;
    logic [SENSE_W-1:0]     route_q, mask_q, edge_q, inv_q, req_clr;
    logic [SENSE_W-1:0]     sense_q, sense_d, req_q;
    logic [LANES*SEL_W-1:0] lane_sel;

    pir_sync #(.W(IN_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(port_in), .dout(ports_s)
    );

    pir_regs #(.W(SENSE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .route_q(route_q), .mask_q(mask_q),
        .edge_q(edge_q), .inv_q(inv_q), .req_clr(req_clr)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_sel
        assign lane_sel[k*SEL_W +: SEL_W] = route_q[k*LANE_W +: SEL_W];
    end

    pir_route #(.PORTS(PORTS), .PORT_W(PORT_W), .LANE_W(LANE_W), .LANES(LANES)) u_route (
        .ports(ports_s), .sel(lane_sel), .inv(inv_q), .qual(sense_q)
    );

    pir_detect #(.W(SENSE_W)) u_detect (
        .clk(clk), .rst_n(rst_n), .qual(sense_q), .edge_mode(edge_q),
        .clr(req_clr), .req(req_q), .qual_d(sense_d)
    );

    // Return the register selected by the bus address.
    always_comb begin
        case (bus_addr)
            ADDR_ROUTE:                   bus_rdata = route_q;
            ADDR_MASK_SET, ADDR_MASK_CLR: bus_rdata = mask_q;
            ADDR_REQ:                     bus_rdata = req_q;
            ADDR_EDGE_SET, ADDR_EDGE_CLR: bus_rdata = edge_q;
            ADDR_INV_SET, ADDR_INV_CLR:   bus_rdata = inv_q;
            ADDR_SENSE:                   bus_rdata = sense_q;
            default:                      bus_rdata = '0;
        endcase
    end

    assign irq_out = |(req_q & mask_q);
endmodule

// File: rtl/pir_checker.sv
// Temporal checks for pin_irq_router, attached by bind.
module pir_checker #(
    parameter int W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_we,
    input logic [pir_pkg::ADDR_W-1:0] bus_addr,
    input logic [W-1:0]               bus_wdata,
    input logic                       irq_out,
    input logic [W-1:0]               req,
    input logic [W-1:0]               edge_mode,
    input logic [W-1:0]               mask,
    input logic [W-1:0]               qual,
    input logic [W-1:0]               qual_d
);
    import pir_pkg::*;

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == ADDR_REQ || bus_addr == ADDR_EDGE_CLR))
        |=> (($past(req & edge_mode) & ~req) == '0)); // R4

    AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req & $past(edge_mode & ~req) & ~$past(qual & ~qual_d)) == '0)); // R4

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((req ^ $past(qual)) & ~$past(edge_mode)) == '0)); // R7

    AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_MASK_CLR && bus_wdata == '1) |=> !irq_out); // R10

    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_out); // R11
endmodule

bind pin_irq_router pir_checker #(.W(SENSE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_out(irq_out), .req(req_q), .edge_mode(edge_q),
    .mask(mask_q), .qual(sense_q), .qual_d(sense_d)
);

// File: tb/pin_irq_router_bench.sv
module pin_irq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pv [4];
    logic [63:0] port_in;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    int          total = 0;
    int          bad = 0;

    assign port_in = {pv[3], pv[2], pv[1], pv[0]};

    always #4 clk = ~clk;

    pin_irq_router u_pin_irq_router (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    function automatic logic [31:0] exp_sense(input logic [31:0] route, input logic [31:0] inv);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) begin
            r[k*8 +: 8] = pv[route[k*8 +: 2]][(k % 2)*8 +: 8];
        end
        return r ^ inv;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), d);
            chk("R1 reg zero after reset", d, 32'd0);
        end
        chk("R1 irq low after reset", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_pairs();
        logic [31:0] d;
        wr(4'd1, 32'h0000F0F0);
        wr(4'd1, 32'h00000000);
        rd(4'd2, d); chk("R9 mask via clr addr", d, 32'h0000F0F0);
        wr(4'd2, 32'h000000F0);
        rd(4'd1, d); chk("R9 mask after clear", d, 32'h0000F000);
        wr(4'd4, 32'hA5000000);
        wr(4'd5, 32'h05000000);
        rd(4'd4, d); chk("R9 edge pair", d, 32'hA0000000);
        wr(4'd6, 32'h00300003);
        wr(4'd7, 32'h00000001);
        rd(4'd7, d); chk("R9 invert pair", d, 32'h00300002);
        wr(4'd0, 32'h12345678);
        rd(4'd0, d); chk("R9 route read/write", d, 32'h12345678);
        wr(4'd2, 32'hFFFFFFFF); wr(4'd5, 32'hFFFFFFFF); wr(4'd7, 32'hFFFFFFFF);
        wr(4'd0, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        pv[0] = 16'h1234; pv[1] = 16'h5678; pv[2] = 16'h9ABC; pv[3] = 16'hDEF0;
        wr(4'd0, 32'hFDFEFF00);
        settle();
        rd(4'd8, d); chk("R2 R12 routing, upper select bits ignored", d, 32'h56BCDE34);
        chk("R2 routing model", d, exp_sense(32'hFDFEFF00, 32'h0));
        wr(4'd0, 32'h01020302);
        wr(4'd6, 32'h0000FF00);
        settle();
        rd(4'd8, d); chk("R12 routing with invert", d, 32'h56BC21BC);
        wr(4'd7, 32'hFFFFFFFF);
        wr(4'd0, 32'h0);
        pv[0] = 0; pv[1] = 0; pv[2] = 0; pv[3] = 0;
        settle();
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(4'd4, 32'h1);
        wr(4'd1, 32'h1);
        wr(4'd3, 32'hFFFFFFFF);
        @(negedge clk); pv[0][0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_addr = 4'd3; #1;
        chk("R3 not yet visible after edge 1", bus_rdata & 32'h1, 32'h0);
        @(posedge clk);
        @(negedge clk); #1;
        chk("R3 visible after edge 2", bus_rdata & 32'h1, 32'h1);
        pv[0][0] = 1'b0;
        settle();
        rd(4'd3, d); chk("R4 edge request held", d & 32'h1, 32'h1);
        chk("R11 irq with masked-in request", {31'd0, irq_out}, 32'd1);
        wr(4'd3, 32'h0);
        rd(4'd3, d); chk("R5 writing zero keeps request", d & 32'h1, 32'h1);
        wr(4'd3, 32'h1);
        rd(4'd3, d); chk("R5 writing one clears request", d & 32'h1, 32'h0);
        chk("R11 irq low after clear", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        @(negedge clk); pv[0][0] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = 4'd3; bus_wdata = 32'h1;
        @(posedge clk); #1;
        bus_we = 1'b0;
        rd(4'd3, d); chk("R6 edge wins over same-cycle clear", d & 32'h1, 32'h1);
        pv[0][0] = 1'b0;
        settle();
        wr(4'd3, 32'h1);
        wr(4'd2, 32'hFFFFFFFF);
        wr(4'd5, 32'hFFFFFFFF);
    endtask

    task automatic t_level();
        logic [31:0] d;
        pv[1][1] = 1'b1;
        wr(4'd0, 32'h00000001);
        settle();
        rd(4'd3, d); chk("R7 level request follows high", d & 32'h2, 32'h2);
        wr(4'd3, 32'h2);
        rd(4'd3, d); chk("R7 clear has no lasting effect", d & 32'h2, 32'h2);
        pv[1][1] = 1'b0;
        settle();
        rd(4'd3, d); chk("R7 level request follows low", d & 32'h2, 32'h0);
        wr(4'd0, 32'h0);
    endtask

    task automatic t_invert();
        logic [31:0] d;
        wr(4'd6, 32'h4);
        settle();
        rd(4'd3, d); chk("R8 active-low level request", d & 32'h4, 32'h4);
        pv[0][2] = 1'b1;
        settle();
        rd(4'd3, d); chk("R8 active-low level released", d & 32'h4, 32'h0);
        pv[0][3] = 1'b1;
        settle();
        wr(4'd6, 32'h8);
        wr(4'd4, 32'h8);
        wr(4'd3, 32'h8);
        settle();
        rd(4'd3, d); chk("R8 no request before falling edge", d & 32'h8, 32'h0);
        pv[0][3] = 1'b0;
        settle();
        rd(4'd3, d); chk("R8 falling edge latched", d & 32'h8, 32'h8);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(4'd1, 32'h4);
        chk("R11 masked-out pending bit gives no irq", {31'd0, irq_out}, 32'd0);
        wr(4'd1, 32'hFFFFFFFF);
        chk("R11 irq with all masked in", {31'd0, irq_out}, 32'd1);
        wr(4'd2, 32'hFFFFFFFF);
        @(negedge clk);
        chk("R10 mask-clear all ones drops irq", {31'd0, irq_out}, 32'd0);
        rd(4'd1, d); chk("R10 mask reads zero", d, 32'd0);
    endtask

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) pv[i] = 16'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_pairs();
        t_route();
        t_edge();
        t_collide();
        t_level();
        t_invert();
        t_mask();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule